// File: doc/BRIEF.md
# Colour Lookup Table Register Front End

This block holds the colour lookup table of a display controller. The table has 260 RGB entries. Entries 0 to 255 are the pixel colours, chosen by an 8-bit pixel value. Entries 256 to 259 are four overlay colours used by a hardware cursor.

Software reaches the table through a 32-bit register bus with three word offsets:

- An index register at offset 0.
- A pixel colour port at offset 4.
- An overlay colour port at offset 12.

Every colour component moves in the top byte of the bus word. A shared red, then green, then blue step counter decides which component the next access at a colour port touches. After the blue step the index advances by one, so software can stream a whole table without reloading the index.

A separate lookup port serves the display pipeline. It turns a 9-bit entry number into a 24-bit {red, green, blue} value one clock later.

Top module: `palette_dac`

## Requirements
- R1: After reset, every entry holds 0x000000 except entries 255, 256 and 258, which hold 0xFFFFFF. After reset the index is 0 and the step counter is at red.
- R2: A full-word write at offset 0 loads the index from data bits 31:24 and returns the step counter to red. This holds even when the write lands in the middle of a red/green/blue sequence.
- R3: Successive full-word writes at offset 4 store data bits 31:24 into the red, then green, then blue component of pixel entry `index`. Data bits 23:0 have no effect.
- R4: Full-word writes at offset 12 store into overlay entry 256 + (index mod 4), using the same red/green/blue order. They advance the index exactly as pixel writes do.
- R5: The access that handles the blue component increments the index modulo 256, so 255 becomes 0, and returns the step counter to red. Red and green accesses leave the index unchanged.
- R6: A full-word read at offset 4 returns, on `bus_rdata` in the cycle after the request, the current component of pixel entry `index` in bits 31:24, with bits 23:0 zero. It advances the step counter and index in the same way as a write.
- R7: A write at any offset other than 0, 4 or 12 changes nothing. A read at any offset other than 4 returns zero and does not advance the step counter.
- R8: An access whose byte enables are not all ones (4'hF) is ignored completely. A read of this kind returns zero.
- R9: The lookup port registers `lk_idx` at a clock edge and presents the stored {R[23:16], G[15:8], B[7:0]} of that entry on `lk_rgb` one cycle later. Entry numbers 260 and above yield 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data; components in bits 31:24 |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| lk_idx | input | 9 | Display lookup entry number |
| lk_rgb | output | 24 | Colour of the registered entry, {R,G,B} |

## Verification
The bench writes all 256 pixel entries with arithmetic patterns per component, with junk in the low data bits. It then reads the whole table back through the lookup port. This exposes swapped lanes, low-bit leakage and any misplaced index.

Read streams that start at index 254 cross the 255-to-0 wrap. Overlay writes that start at index 7 show that only the low two index bits select the overlay entry.

Index writes in the middle of a sequence show that the step counter restarts. Stray offsets and partial byte enables are followed by reads that reveal whether any state moved. A sweep of the lookup port over out-of-range entry numbers shows that they all return zero.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  // Step order red -> green -> blue -> red
  function automatic comp_e comp_next(input comp_e c);
    case (c)
      COMP_R:  return COMP_G;
      COMP_G:  return COMP_B;
      default: return COMP_R;
    endcase
  endfunction

  // Bit offset of a component inside a packed {R,G,B} word
  function automatic int unsigned comp_lsb(input comp_e c, input int unsigned cw);
    return (2 - int'(c)) * cw;
  endfunction

  // Entries that come out of reset white: last pixel entry, first and third overlay
  function automatic logic reset_white(input int unsigned e, input int unsigned base);
    return (e == base - 1) || (e == base) || (e == base + 2);
  endfunction

  // Entry number addressed by an overlay access
  function automatic int unsigned overlay_entry(input int unsigned idx,
                                                input int unsigned base,
                                                input int unsigned n_ovl);
    return base + (idx % n_ovl);
  endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import palette_dac_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int COMP_W   = 8,
  parameter int OVL_N    = 4,
  parameter int OFS_ADDR = 0,
  parameter int OFS_PIX  = 4,
  parameter int OFS_OVL  = 12,
  localparam int N_BASE  = 2 ** IDX_W,
  localparam int ENT_W   = $clog2(N_BASE + OVL_N),
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_en,
  output logic [ENT_W-1:0]  wr_entry,
  output logic [COMP_W-1:0] wr_byte,
  output logic              rd_en,
  output logic [ENT_W-1:0]  rd_entry,
  output comp_e             comp
);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] new_idx;

  // Named internal events
  logic full_word, acc;
  logic hit_idx_w, hit_pix_w, hit_ovl_w, hit_pix_r;
  logic load_evt, step_evt, wrap_evt;

  assign full_word = &be;
  assign acc       = req && full_word;
  assign hit_idx_w = acc &&  we && (addr == ADDR_W'(OFS_ADDR));
  assign hit_pix_w = acc &&  we && (addr == ADDR_W'(OFS_PIX));
  assign hit_ovl_w = acc &&  we && (addr == ADDR_W'(OFS_OVL));
  assign hit_pix_r = acc && !we && (addr == ADDR_W'(OFS_PIX));

  assign load_evt  = hit_idx_w;
  assign step_evt  = hit_pix_w || hit_ovl_w || hit_pix_r;
  assign wrap_evt  = step_evt && (comp == COMP_B);

  assign new_idx   = wdata[DATA_W-1 -: IDX_W];
  assign wr_byte   = wdata[DATA_W-1 -: COMP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      comp <= COMP_R;
    end else if (load_evt) begin
      idx  <= new_idx;
      comp <= COMP_R;
    end else if (step_evt) begin
      comp <= comp_next(comp);
      if (wrap_evt) idx <= idx + 1'b1;
    end
  end

  assign wr_en    = hit_pix_w || hit_ovl_w;
  assign wr_entry = hit_ovl_w ? ENT_W'(overlay_entry(int'(idx), N_BASE, OVL_N))
                              : ENT_W'(idx);
  assign rd_en    = hit_pix_r;
  assign rd_entry = ENT_W'(idx);

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (idx == $past(new_idx)) && (comp == COMP_R)); // R2

  AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !load_evt) |=> (idx == IDX_W'($past(idx) + 1'b1)) && (comp == COMP_R)); // R5

  AST_MID_STEP_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && (comp != COMP_B)) |=> $stable(idx)); // R5

  AST_PARTIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !full_word) |=> $stable(idx) && $stable(comp)); // R8

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_idx_w, hit_pix_w, hit_ovl_w, hit_pix_r})); // R7

endmodule

// File: rtl/pal_store.sv
module pal_store
  import palette_dac_pkg::*;
#(
  parameter int N_BASE  = 256,
  parameter int OVL_N   = 4,
  parameter int COMP_W  = 8,
  parameter int ENT_W   = 9,
  localparam int N_ENT  = N_BASE + OVL_N,
  localparam int RGB_W  = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_entry,
  input  comp_e             wr_comp,
  input  logic [COMP_W-1:0] wr_byte,
  input  logic [ENT_W-1:0]  rd_entry,
  input  comp_e             rd_comp,
  output logic [COMP_W-1:0] rd_byte,
  input  logic [ENT_W-1:0]  lk_idx,
  output logic [RGB_W-1:0]  lk_rgb
);

  logic [RGB_W-1:0] pal [N_ENT];

  function automatic logic [RGB_W-1:0] reset_rgb(input int unsigned e);
    return reset_white(e, N_BASE) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
  endfunction

  logic wr_ok, rd_ok, lk_ok;
  assign wr_ok = wr_en && (wr_entry < ENT_W'(N_ENT));
  assign rd_ok = rd_entry < ENT_W'(N_ENT);
  assign lk_ok = lk_idx   < ENT_W'(N_ENT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) pal[e] <= reset_rgb(e);
    end else if (wr_ok) begin
      pal[wr_entry][comp_lsb(wr_comp, COMP_W) +: COMP_W] <= wr_byte;
    end
  end

  // One component lane per colour, selected by the step counter
  logic [COMP_W-1:0] rd_lane [3];
  for (genvar l = 0; l < 3; l++) begin : g_lane
    assign rd_lane[l] = rd_ok ? pal[rd_entry][(2 - l) * COMP_W +: COMP_W] : '0;
  end
  assign rd_byte = (rd_comp == COMP_R) ? rd_lane[0] :
                   (rd_comp == COMP_G) ? rd_lane[1] : rd_lane[2];

  always_ff @(posedge clk) begin
    if (!rst_n) lk_rgb <= '0;
    else        lk_rgb <= lk_ok ? pal[lk_idx] : '0;
  end

  AST_LK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ok |=> (lk_rgb == '0)); // R9

  AST_WR_TARGETS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_ok); // R4

endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_dac_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int OVL_N    = 4,
  parameter int COMP_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int OFS_ADDR = 0,
  parameter int OFS_PIX  = 4,
  parameter int OFS_OVL  = 12,
  localparam int N_BASE  = 2 ** IDX_W,
  localparam int ENT_W   = $clog2(N_BASE + OVL_N),
  localparam int BE_W    = DATA_W / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BE_W-1:0]     bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [ENT_W-1:0]    lk_idx,
  output logic [3*COMP_W-1:0] lk_rgb
);

  logic              wr_en, rd_en;
  logic [ENT_W-1:0]  wr_entry, rd_entry;
  logic [COMP_W-1:0] wr_byte, rd_byte;
  comp_e             comp;

  pal_seq #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMP_W(COMP_W),
    .OVL_N(OVL_N), .OFS_ADDR(OFS_ADDR), .OFS_PIX(OFS_PIX), .OFS_OVL(OFS_OVL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .wr_en(wr_en), .wr_entry(wr_entry),
    .wr_byte(wr_byte), .rd_en(rd_en), .rd_entry(rd_entry), .comp(comp)
  );

  pal_store #(
    .N_BASE(N_BASE), .OVL_N(OVL_N), .COMP_W(COMP_W), .ENT_W(ENT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
    .wr_comp(comp), .wr_byte(wr_byte), .rd_entry(rd_entry), .rd_comp(comp),
    .rd_byte(rd_byte), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= {rd_byte, {(DATA_W-COMP_W){1'b0}}};
    else            bus_rdata <= '0;
  end

  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && ((bus_addr != ADDR_W'(OFS_PIX)) || !(&bus_be)))
      |=> (bus_rdata == '0)); // R7

  AST_RDATA_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> (bus_rdata == '0)); // R6

endmodule

// File: tb/palette_dac_bench.sv
`timescale 1ns/1ps
module palette_dac_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  always #2.5 clk = ~clk;

  palette_dac u_palette_dac (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  int n_cmp = 0, n_bad = 0;

  // Reference table and sequencer state
  logic [7:0] mr [260], mg [260], mb [260];
  logic [7:0] m_idx;
  int         m_step;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int e = 0; e < 260; e++) begin
      logic [7:0] v;
      v = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
      mr[e] = v; mg[e] = v; mb[e] = v;
    end
    m_idx = 0; m_step = 0;
  endtask

  task automatic model_advance();
    if (m_step == 2) begin m_step = 0; m_idx = m_idx + 8'd1; end
    else m_step++;
  endtask

  // One bus cycle; returns expected read data from the reference
  task automatic bus_op(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] exp_rd);
    exp_rd = 32'h0;
    if (be == 4'hF) begin
      if (we) begin
        if (a == 4'd0) begin m_idx = d[31:24]; m_step = 0; end
        else if (a == 4'd4 || a == 4'd12) begin
          int e;
          e = (a == 4'd4) ? int'(m_idx) : 256 + int'(m_idx % 4);
          case (m_step)
            0: mr[e] = d[31:24];
            1: mg[e] = d[31:24];
            default: mb[e] = d[31:24];
          endcase
          model_advance();
        end
      end else if (a == 4'd4) begin
        logic [7:0] c;
        c = (m_step == 0) ? mr[m_idx] : (m_step == 1) ? mg[m_idx] : mb[m_idx];
        exp_rd = {c, 24'h0};
        model_advance();
      end
    end
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] x;
    bus_op(1'b1, a, d, 4'hF, x);
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [3:0] be);
    logic [31:0] x;
    bus_op(1'b0, a, 32'h0, be, x);
    check(req, bus_rdata, x);
  endtask

  task automatic lk_check(input string req, input int e);
    logic [23:0] exp;
    exp = (e < 260) ? {mr[e], mg[e], mb[e]} : 24'h0;
    @(negedge clk); lk_idx = 9'(e);
    @(negedge clk);
    check(req, {8'h0, lk_rgb}, {8'h0, exp});
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents via the lookup port, and the reset index/step state
    check("R1 rdata after reset", bus_rdata, 32'h0);
    for (int e = 0; e < 260; e++) lk_check("R1 reset table", e);
    wr(4'd0, 32'hFF00_0000);
    for (int k = 0; k < 3; k++) rd_check("R1 white entry 255", 4'd4, 4'hF);

    // R3, R5: fill all pixel entries in one stream from index 0 (wraps 255->0)
    wr(4'd0, 32'h0000_0000);
    for (int i = 0; i < 256; i++) begin
      wr(4'd4, {8'((i * 7 + 3) & 255), 8'(i), 16'hBEEF});
      wr(4'd4, {8'(i) ^ 8'hA5, 24'hFFFFFF});
      wr(4'd4, {8'(255 - i), 24'h123456});
    end
    for (int e = 0; e < 260; e++) lk_check("R3 pixel fill", e);

    // R6, R5: read stream across the index wrap
    wr(4'd0, 32'hFE00_0000);
    for (int k = 0; k < 9; k++) rd_check("R6 read walk across wrap", 4'd4, 4'hF);

    // R4: overlay writes start at index 7 (entry 259) and continue at 8 (entry 256)
    wr(4'd0, 32'h0700_0000);
    wr(4'd12, 32'h1100_0000); wr(4'd12, 32'h2200_0000); wr(4'd12, 32'h3300_0000);
    wr(4'd12, 32'h4400_0000); wr(4'd12, 32'h5500_0000); wr(4'd12, 32'h6600_0000);
    for (int e = 256; e < 260; e++) lk_check("R4 overlay entries", e);
    for (int k = 0; k < 3; k++) rd_check("R4 index advanced by overlay", 4'd4, 4'hF);

    // R2: index load mid-sequence restarts at red
    wr(4'd0, 32'h0A00_0000);
    wr(4'd4, 32'h9900_0000);
    wr(4'd0, 32'h1400_0000);
    wr(4'd4, 32'hC100_0000); wr(4'd4, 32'hC200_0000); wr(4'd4, 32'hC300_0000);
    lk_check("R2 partial entry 10", 10);
    lk_check("R2 restarted entry 20", 20);
    rd_check("R2 index after restart", 4'd4, 4'hF);

    // R7: stray offsets; the read stream must continue where it was
    wr(4'd0, 32'h3000_0000);
    rd_check("R7 first red", 4'd4, 4'hF);
    wr(4'd8, 32'h7700_0000);
    wr(4'd2, 32'h0100_0000);
    rd_check("R7 stray read offset 8", 4'd8, 4'hF);
    rd_check("R7 stray read offset 0", 4'd0, 4'hF);
    rd_check("R7 stream continues green", 4'd4, 4'hF);
    rd_check("R7 stream continues blue", 4'd4, 4'hF);
    lk_check("R7 entry 48 untouched", 48);

    // R8: partial byte enables are ignored
    wr(4'd0, 32'h4000_0000);
    begin
      logic [31:0] x;
      bus_op(1'b1, 4'd4, 32'hEE00_0000, 4'h8, x);
      bus_op(1'b1, 4'd0, 32'h9000_0000, 4'h7, x);
      bus_op(1'b1, 4'd12, 32'hEE00_0000, 4'hE, x);
    end
    rd_check("R8 partial read returns zero", 4'd4, 4'h3);
    for (int k = 0; k < 3; k++) rd_check("R8 state unchanged", 4'd4, 4'hF);
    lk_check("R8 entry 64 untouched", 64);
    lk_check("R8 entry 144 untouched", 144);

    // R9: out-of-range lookups
    for (int e = 260; e < 512; e++) lk_check("R9 out of range lookup", e);
    lk_check("R9 back in range", 259);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule